// File: doc/BRIEF.md
# Oversampled Serial-Stream Pulse Timer

This block turns a deserialized detector stream into timing records. Every reference clock cycle it takes one 16-bit sample word. Each bit covers one sixteenth of the 6.4 ns cycle, which is 400 ps. The most significant bit is the earliest sample in time. A free-running coarse counter numbers the words. When the first set bit of a pulse shows up, the block notes the coarse number of that word and the count of zero bits in front of the set bit. The arrival time is then coarse × 6.4 ns + fine × 400 ps. Both time and width are good to ±200 ps.

After the leading edge, the block counts set bits until the first clear bit, and that count is the pulse width. The count may run across any number of fully set words and saturates at a configurable ceiling. Each pulse yields one record on a valid/ready output.

While a record waits unaccepted, incoming words are thrown away. A discarded word that holds any set bit raises a sticky overflow flag.

Top module: `tdc_stream_decoder`

## Requirements
- R1: After synchronous reset (`rst` high, active high), `rec_valid` and `ovf_flag` are 0. The first word presented after reset is numbered coarse 0.
- R2: The coarse counter advances by one every clock cycle. A record's `rec_coarse` is the number of the word holding the pulse's first set bit.
- R3: `rec_fine` is the count of zero bits above the first set bit, counted from bit 15 (the earliest sample). Examples: 0xFFFF gives 0, 0x7FFF gives 1, 0x3FFF gives 2, 0x0FFF gives 4, 0x0001 gives 15.
- R4: A pulse that ends inside the word where it starts has a width equal to its run of set bits. Bits below the first clear bit that follows the run are not searched. Example: 0x0830 gives one record with fine 4 and width 1.
- R5: A pulse that reaches bit 0 continues into the following words. Each all-ones word adds 16. The first word that is not all ones adds its count of set bits above its first clear bit, and that word ends the pulse. Example: 0x0001, 0xFFFF, 0xF000 gives fine 15 and width 21.
- R6: The width saturates at the parameter `MAX_WIDTH` and never exceeds it.
- R7: `rec_valid` rises in the cycle after the edge that processes the word ending a pulse. While `rec_valid` is high and `rec_ready` is low, the record fields hold stable. Exactly one record is produced per pulse.
- R8: A word that arrives while `rec_valid` is high and `rec_ready` is low is discarded. If that word is non-zero, `ovf_flag` is set and stays set until reset. A discarded all-zero word leaves `ovf_flag` at 0.
- R9: All-zero words outside a pulse produce no record.
- R10: A pulse that ends exactly at a word boundary (the next word has bit 15 clear) is reported when that next word arrives. Its coarse and fine come from the starting word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one sample word per cycle |
| rst | input | 1 | Synchronous reset, active high |
| smp_word | input | 16 | Deserialized samples, bit 15 earliest |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_coarse | output | 32 | Coarse word number of the leading edge |
| rec_fine | output | 4 | Zero bits ahead of the leading edge |
| rec_width | output | 16 | Pulse width in sample bits, saturating |
| ovf_flag | output | 1 | Sticky: a non-zero word was discarded |

## Verification
The hardest situation to reach is a dropped word while the output is stalled, because a record must already be pending when the word arrives. The bench holds `rec_ready` low and sends a one-bit pulse to fill the record stage. It then sends an all-zero word and afterwards a non-zero word. After each word it looks at the still-pending record and the overflow flag, before it releases `ready`. Saturation needs a pulse longer than the ceiling, so the bench builds the design with a small `MAX_WIDTH` and sends a chain of all-ones words.

// File: rtl/tdc_dec_pkg.sv
package tdc_dec_pkg;

    parameter int unsigned SMP_W    = 16;
    parameter int unsigned COARSE_W = 32;
    parameter int unsigned WID_W    = 16;
    localparam int unsigned FINE_W  = $clog2(SMP_W);
    localparam int unsigned CNT_W   = FINE_W + 1;
    localparam logic [CNT_W-1:0] SMP_CNT = CNT_W'(SMP_W);

    typedef logic [SMP_W-1:0]    smp_t;
    typedef logic [CNT_W-1:0]    bitcnt_t;
    typedef logic [COARSE_W-1:0] coarse_t;
    typedef logic [FINE_W-1:0]   fine_t;
    typedef logic [WID_W-1:0]    width_t;

    typedef enum logic {TRK_IDLE, TRK_RUN} trk_state_e;

    typedef struct packed {
        coarse_t coarse;
        fine_t   fine;
        width_t  width;
    } tdc_rec_t;

    // number of clear bits above the first set bit (SMP_W if none)
    function automatic bitcnt_t lead_zeros(input smp_t w);
        bitcnt_t n;
        logic    seen;
        n    = '0;
        seen = 1'b0;
        for (int i = SMP_W - 1; i >= 0; i--) begin
            if (w[i])       seen = 1'b1;
            else if (!seen) n = n + 1'b1;
        end
        return n;
    endfunction

    function automatic bitcnt_t lead_ones(input smp_t w);
        return lead_zeros(~w);
    endfunction

    function automatic width_t sat_add(input width_t acc, input bitcnt_t add,
                                       input width_t ceil);
        logic [WID_W:0] s;
        s = {1'b0, acc} + {{(WID_W + 1 - CNT_W){1'b0}}, add};
        if (s > {1'b0, ceil}) return ceil;
        return s[WID_W-1:0];
    endfunction

endpackage

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr
    import tdc_dec_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    output coarse_t cnt
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    AST_COARSE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt == $past(cnt) + 1'b1)   // R2
        else $error("coarse counter skipped");
endmodule

// File: rtl/tdc_edge_find.sv
module tdc_edge_find
    import tdc_dec_pkg::*;
(
    input  smp_t    word,
    output logic    hit,
    output fine_t   lz,
    output bitcnt_t head_run,
    output logic    head_open,
    output bitcnt_t tail_ones,
    output logic    tail_full
);
    bitcnt_t zc;
    smp_t    aligned;

    always_comb begin
        zc        = lead_zeros(word);
        hit       = |word;
        lz        = zc[FINE_W-1:0];
        aligned   = word << zc;
        head_run  = lead_ones(aligned);
        head_open = hit && (head_run == SMP_CNT - zc);
        tail_ones = lead_ones(word);
        tail_full = &word;
    end
endmodule

// File: rtl/tdc_pulse_trk.sv
module tdc_pulse_trk
    import tdc_dec_pkg::*;
#(
    parameter width_t CEIL = width_t'(1024)
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     stall,
    input  coarse_t  coarse,
    input  logic     hit,
    input  fine_t    lz,
    input  bitcnt_t  head_run,
    input  logic     head_open,
    input  bitcnt_t  tail_ones,
    input  logic     tail_full,
    output logic     emit,
    output tdc_rec_t emit_rec,
    output logic     in_run
);
    trk_state_e state, state_n;
    coarse_t    st_coarse, st_coarse_n;
    fine_t      st_fine, st_fine_n;
    width_t     acc, acc_n;

    always_comb begin
        state_n     = state;
        st_coarse_n = st_coarse;
        st_fine_n   = st_fine;
        acc_n       = acc;
        emit        = 1'b0;
        emit_rec    = '0;
        if (!stall) begin
            case (state)
                TRK_IDLE: if (hit) begin
                    if (head_open) begin
                        state_n     = TRK_RUN;
                        st_coarse_n = coarse;
                        st_fine_n   = lz;
                        acc_n       = sat_add('0, head_run, CEIL);
                    end else begin
                        emit     = 1'b1;
                        emit_rec = '{coarse: coarse, fine: lz,
                                     width: sat_add('0, head_run, CEIL)};
                    end
                end
                TRK_RUN: begin
                    if (tail_full) begin
                        acc_n = sat_add(acc, SMP_CNT, CEIL);
                    end else begin
                        state_n  = TRK_IDLE;
                        emit     = 1'b1;
                        emit_rec = '{coarse: st_coarse, fine: st_fine,
                                     width: sat_add(acc, tail_ones, CEIL)};
                    end
                end
                default: state_n = TRK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= TRK_IDLE;
            st_coarse <= '0;
            st_fine   <= '0;
            acc       <= '0;
        end else begin
            state     <= state_n;
            st_coarse <= st_coarse_n;
            st_fine   <= st_fine_n;
            acc       <= acc_n;
        end
    end

    assign in_run = (state == TRK_RUN);

    AST_WIDTH_CEIL: assert property (@(posedge clk) disable iff (rst)
        emit |-> (emit_rec.width <= CEIL && emit_rec.width != '0))   // R6
        else $error("width outside range");
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        stall |=> state == $past(state) && acc == $past(acc))   // R8
        else $error("tracker moved while stalled");
endmodule

// File: rtl/tdc_rec_out.sv
module tdc_rec_out
    import tdc_dec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  tdc_rec_t rec_in,
    input  logic     ready,
    input  logic     word_nz,
    output logic     valid,
    output tdc_rec_t rec_q,
    output logic     stalled,
    output logic     ovf
);
    assign stalled = valid && !ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            rec_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (load) begin
                valid <= 1'b1;
                rec_q <= rec_in;
            end else if (ready) begin
                valid <= 1'b0;
            end
            if (stalled && word_nz) ovf <= 1'b1;
        end
    end

    AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && rec_q == $past(rec_q)))   // R7
        else $error("pending record changed");
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf)   // R8
        else $error("overflow flag cleared");
    AST_NO_LOAD_STALLED: assert property (@(posedge clk) disable iff (rst)
        stalled |-> !load)   // R8
        else $error("record overwritten while stalled");
endmodule

// File: rtl/tdc_stream_decoder.sv
module tdc_stream_decoder
    import tdc_dec_pkg::*;
#(
    parameter int unsigned MAX_WIDTH = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SMP_W-1:0]    smp_word,
    output logic                rec_valid,
    input  logic                rec_ready,
    output logic [COARSE_W-1:0] rec_coarse,
    output logic [FINE_W-1:0]   rec_fine,
    output logic [WID_W-1:0]    rec_width,
    output logic                ovf_flag
);
    localparam width_t CEIL = width_t'(MAX_WIDTH);

    coarse_t  coarse;
    logic     hit, head_open, tail_full;
    fine_t    lz;
    bitcnt_t  head_run, tail_ones;
    logic     stall, emit, in_run;
    tdc_rec_t emit_rec, rec_q;

    tdc_coarse_ctr u_ctr (.clk(clk), .rst(rst), .cnt(coarse));

    tdc_edge_find u_edge (
        .word(smp_word), .hit(hit), .lz(lz), .head_run(head_run),
        .head_open(head_open), .tail_ones(tail_ones), .tail_full(tail_full)
    );

    tdc_pulse_trk #(.CEIL(CEIL)) u_trk (
        .clk(clk), .rst(rst), .stall(stall), .coarse(coarse),
        .hit(hit), .lz(lz), .head_run(head_run), .head_open(head_open),
        .tail_ones(tail_ones), .tail_full(tail_full),
        .emit(emit), .emit_rec(emit_rec), .in_run(in_run)
    );

    tdc_rec_out u_out (
        .clk(clk), .rst(rst), .load(emit), .rec_in(emit_rec),
        .ready(rec_ready), .word_nz(hit), .valid(rec_valid),
        .rec_q(rec_q), .stalled(stall), .ovf(ovf_flag)
    );

    assign rec_coarse = rec_q.coarse;
    assign rec_fine   = rec_q.fine;
    assign rec_width  = rec_q.width;

    AST_RUN_NO_PENDING: assert property (@(posedge clk) disable iff (rst)
        in_run |-> !rec_valid)   // R7
        else $error("record pending during pulse");
endmodule

// File: tb/tdc_stream_decoder_tb.sv
module tdc_stream_decoder_tb_top;
    localparam int MAXW = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] smp_word = '0;
    logic        rec_ready = 1'b1;
    logic        rec_valid, ovf_flag;
    logic [31:0] rec_coarse;
    logic [3:0]  rec_fine;
    logic [15:0] rec_width;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [31:0] coarse;
        logic [3:0]  fine;
        logic [15:0] width;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    tdc_stream_decoder #(.MAX_WIDTH(MAXW)) dut_i (
        .clk(clk), .rst(rst), .smp_word(smp_word), .rec_valid(rec_valid),
        .rec_ready(rec_ready), .rec_coarse(rec_coarse), .rec_fine(rec_fine),
        .rec_width(rec_width), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] w);
        smp_word = w;
        @(posedge clk);
        cyc++;
        #1;
    endtask

    task automatic expect_rec(input int c, input int f, input int w, input string tag);
        exp_t e;
        e.coarse = 32'(c); e.fine = 4'(f); e.width = 16'(w); e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compare each accepted record against the scoreboard
    always @(negedge clk) begin
        if (!rst && rec_valid && rec_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected record coarse", rec_coarse, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rec_coarse == e.coarse, e.tag, "coarse", rec_coarse, e.coarse);
                check(rec_fine == e.fine, e.tag, "fine", rec_fine, e.fine);
                check(rec_width == e.width, e.tag, "width", rec_width, e.width);
            end
        end
    end

    initial begin
        #(200000 * 5);
        check(1'b0, "watchdog", "timeout", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(rec_valid == 1'b0, "R1", "valid in reset", rec_valid, 0);
        check(ovf_flag == 1'b0, "R1", "ovf in reset", ovf_flag, 0);
        rst = 1'b0;
        cyc = 0;

        // R1 R2: first word after reset is coarse 0
        expect_rec(0, 0, 1, "R1");
        put(16'h8000);
        put(16'h0000);

        // R3: fine offsets within one word
        expect_rec(cyc, 4, 11, "R3"); put(16'h0FFE);
        expect_rec(cyc, 4, 3, "R3");  put(16'h0E00);
        expect_rec(cyc, 4, 1, "R3");  put(16'h0800);
        put(16'h0000);

        // R4: bits after the pulse end are not searched
        expect_rec(cyc, 4, 1, "R4");  put(16'h0830);
        put(16'h0000);

        // R5: pulses spanning words
        expect_rec(cyc, 0, 21, "R5");  put(16'hFFFF); put(16'hF800);
        expect_rec(cyc, 1, 21, "R5");  put(16'h7FFF); put(16'hFC00);
        expect_rec(cyc, 2, 21, "R5");  put(16'h3FFF); put(16'hFE00);
        expect_rec(cyc, 4, 21, "R5");  put(16'h0FFF); put(16'hFF80);
        expect_rec(cyc, 15, 21, "R5"); put(16'h0001); put(16'hFFFF); put(16'hF000);
        put(16'h0000);

        // R10: end at a word boundary
        expect_rec(cyc, 4, 12, "R10"); put(16'h0FFF); put(16'h0000);
        expect_rec(cyc, 4, 12, "R10"); put(16'h0FFF); put(16'h7FFF);
        put(16'h0000);

        // R7: back-to-back pulses in consecutive words
        expect_rec(cyc, 0, 1, "R7");     put(16'h8000);
        expect_rec(cyc, 1, 1, "R7");     put(16'h4000);
        put(16'h0000);

        // R6: saturation
        expect_rec(cyc, 8, 39, "R6"); put(16'h00FF); put(16'hFFFF); put(16'hFFFE);
        expect_rec(cyc, 0, 40, "R6"); put(16'hFFFF); put(16'hFFFF); put(16'hFFFF); put(16'h0000);
        expect_rec(cyc, 8, 40, "R6"); put(16'h00FF); put(16'hFFFF); put(16'hFFFF); put(16'h8000);
        put(16'h0000);

        // R9 R2: long idle stretch, then a pulse at a known word number
        for (int i = 0; i < 300; i++) put(16'h0000);
        check(rec_valid == 1'b0, "R9", "valid after idle", rec_valid, 0);
        expect_rec(cyc, 6, 2, "R2"); put(16'h0300);
        put(16'h0000);

        // R8 R7: stall with a pending record
        check(ovf_flag == 1'b0, "R8", "ovf before stall", ovf_flag, 0);
        rec_ready = 1'b0;
        begin
            int c0;
            c0 = cyc;
            put(16'h0800);
            check(rec_valid == 1'b1, "R7", "pending valid", rec_valid, 1);
            put(16'h0000);
            check(ovf_flag == 1'b0, "R8", "ovf after zero drop", ovf_flag, 0);
            check(rec_coarse == 32'(c0), "R7", "held coarse", rec_coarse, c0);
            put(16'h00F0);
            check(ovf_flag == 1'b1, "R8", "ovf after nonzero drop", ovf_flag, 1);
            check(rec_valid == 1'b1 && rec_width == 16'd1, "R7", "held width", rec_width, 1);
            check(rec_fine == 4'd4, "R7", "held fine", rec_fine, 4);
            expect_rec(c0, 4, 1, "R8");
        end
        rec_ready = 1'b1;
        put(16'h0000);
        put(16'h0000);
        check(rec_valid == 1'b0, "R8", "dropped word made no record", rec_valid, 0);
        check(ovf_flag == 1'b1, "R8", "ovf sticky", ovf_flag, 1);

        repeat (4) put(16'h0000);
        check(sb.size() == 0, "R7", "records missing", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule